// File: doc/BRIEF.md
# Exception and interrupt entry sequencer

This block sits next to a small processor core and handles the entry side of exceptions and interrupts. Three kinds of events can be raised: a software break that carries an 8-bit trap number, an MMU miss, and a 32-bit vector of pending external interrupt lines. When idle, the block takes exactly one of the events requested in the current cycle. It works out a vector number, computes the handler word address from the exception base, and reads that word through a simple request/response read port.

When the read response arrives, the block publishes three values for the core to load, all in one cycle: the handler address as the new PC, the exception return address, and a shifted copy of the condition-code status word. A one-cycle done strobe marks that update. The return address depends on the kind of event. A break resumes after the two-byte break instruction. A miss and an interrupt resume at the current PC, so a faulting instruction is tried again.

Top module: `exc_entry_seq`

## Requirements
- R1: The read port address is `ebp + 4*vector` modulo 2^32, and `new_pc` is loaded with the word returned for that read.
- R2: A software break (`brk_req`) uses `brk_trap` (an 8-bit unsigned value) as its vector number, and `new_erp` is set to `cur_pc + 2`.
- R3: An MMU miss (`mmu_req`) uses vector number 4, and `new_erp` is set to `cur_pc`.
- R4: An external interrupt uses vector number 0x30 plus the index of the highest set bit of `irq_pend`, and `new_erp` is set to `cur_pc`.
- R5: An external interrupt is not taken when `irq_pend` is zero or when bit 8 of `cur_ccs` (the interrupt-enable flag) is clear; in that case no read is issued and no output changes.
- R6: For every event taken, `new_ccs` holds `cur_ccs[31:30]` in bits 31:30 and `cur_ccs[19:0]` in bits 29:10, and bits 9:0 are zero. The source word is the one sampled when the event was accepted.
- R7: If events are requested in the same cycle, a break takes priority over an MMU miss, and an MMU miss takes priority over external interrupts.
- R8: The read handshake works as follows. `rd_valid` rises the cycle after an event is accepted. It stays high, with `rd_addr` stable, until `rd_ready` is seen. After that, the first `rd_rvalid` completes the fetch. `done` is then high for exactly one cycle, and `new_pc`, `new_erp` and `new_ccs` change only in that cycle. After reset, `rd_valid` and `done` are low and the three result outputs are zero.
- R9: Requests are ignored from acceptance until `done` has fallen. The block is idle in the cycle after `done`, so `rd_valid` is low in that cycle.
- R10: Return-address and vector-address arithmetic wraps modulo 2^32. For example, `cur_pc = 0xFFFFFFFF` with a break gives `new_erp = 0x00000001`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brk_req | input | 1 | Software break request |
| brk_trap | input | 8 | Trap number of the break |
| mmu_req | input | 1 | MMU miss request |
| irq_pend | input | 32 | Pending external interrupt lines |
| cur_pc | input | 32 | Current program counter |
| cur_ccs | input | 32 | Current condition-code status word |
| ebp | input | 32 | Exception vector table base |
| rd_valid | output | 1 | Vector read request valid |
| rd_addr | output | 32 | Vector read address |
| rd_ready | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read response valid |
| rd_rdata | input | 32 | Read response data (handler address) |
| done | output | 1 | One-cycle strobe: results updated |
| new_pc | output | 32 | Handler address for the PC |
| new_erp | output | 32 | Exception return address |
| new_ccs | output | 32 | Shifted status word |

## Verification
The bench tries each event kind on its own, and each result separates the vector number and return-address rule of that kind from the others. Combined requests (break with miss and interrupts, and miss with interrupts) show whether priority is honoured. Interrupt vectors at the lowest and highest set bits, and with a lower bit also set, show whether the highest index is chosen. Requests with the enable flag clear or with no pending line must produce no read, while requests raised during a slow fetch must not disturb the event in progress; wrap-around values for the PC and base expose truncation or carry errors.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/exc_prio_pick.sv
// Chooses one event and forms its vector number.
module exc_prio_pick #(
    parameter int NIRQ     = 32,
    parameter int TRAPW    = 8,
    parameter int VECW     = 8,
    parameter int IRQ_BASE = 48,
    parameter int MMU_VEC  = 4
) (
    input  logic             brk_req,
    input  logic [TRAPW-1:0] brk_trap,
    input  logic             mmu_req,
    input  logic [NIRQ-1:0]  irq_pend,
    input  logic             irq_en,
    output logic             take_o,
    output logic             is_brk_o,
    output logic [VECW-1:0]  vec_o
);
    localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    logic [IDXW-1:0] hi_idx;
    logic            any_irq;

    // highest-numbered pending line wins
    always_comb begin
        hi_idx  = '0;
        any_irq = 1'b0;
        for (int i = 0; i < NIRQ; i++) begin
            if (irq_pend[i]) begin
                hi_idx  = IDXW'(i);
                any_irq = 1'b1;
            end
        end
    end

    always_comb begin
        take_o   = 1'b0;
        is_brk_o = 1'b0;
        vec_o    = '0;
        if (brk_req) begin
            take_o   = 1'b1;
            is_brk_o = 1'b1;
            vec_o    = VECW'(brk_trap);
        end else if (mmu_req) begin
            take_o = 1'b1;
            vec_o  = VECW'(MMU_VEC);
        end else if (any_irq && irq_en) begin
            take_o = 1'b1;
            vec_o  = VECW'(IRQ_BASE) + VECW'(hi_idx);
        end
    end
endmodule

// File: rtl/exc_ccs_shift.sv
// Pushes the flag field up inside the status word on entry.
module exc_ccs_shift #(
    parameter int XLEN  = 32,
    parameter int KEEP  = 2,
    parameter int SHIFT = 10
) (
    input  logic [XLEN-1:0] ccs_i,
    output logic [XLEN-1:0] ccs_o
);
    localparam int LOW = XLEN - KEEP - SHIFT;

    logic unused_bits;
    assign unused_bits = ^ccs_i[XLEN-KEEP-1:LOW];

    assign ccs_o = {ccs_i[XLEN-1:XLEN-KEEP], ccs_i[LOW-1:0], {SHIFT{1'b0}}};
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NIRQ      = 32,
    parameter int TRAPW     = 8,
    parameter int IRQ_BASE  = 48,
    parameter int MMU_VEC   = 4,
    parameter int IFLAG_BIT = 8,
    parameter int CCS_KEEP  = 2,
    parameter int CCS_SHIFT = 10,
    parameter int BRK_STEP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             brk_req,
    input  logic [TRAPW-1:0] brk_trap,
    input  logic             mmu_req,
    input  logic [NIRQ-1:0]  irq_pend,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_ccs,
    input  logic [XLEN-1:0]  ebp,
    output logic             rd_valid,
    output logic [XLEN-1:0]  rd_addr,
    input  logic             rd_ready,
    input  logic             rd_rvalid,
    input  logic [XLEN-1:0]  rd_rdata,
    output logic             done,
    output logic [XLEN-1:0]  new_pc,
    output logic [XLEN-1:0]  new_erp,
    output logic [XLEN-1:0]  new_ccs
);
    localparam int VECW = TRAPW;

    typedef struct packed {
        seq_state_e      state;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] erp_h;
        logic [XLEN-1:0] ccs_h;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] erp;
        logic [XLEN-1:0] ccs;
        logic            done;
    } seq_regs_t;

    seq_regs_t q, d;

    logic            take;
    logic            is_brk;
    logic [VECW-1:0] vec;
    logic [XLEN-1:0] ccs_shifted;

    exc_prio_pick #(
        .NIRQ    (NIRQ),
        .TRAPW   (TRAPW),
        .VECW    (VECW),
        .IRQ_BASE(IRQ_BASE),
        .MMU_VEC (MMU_VEC)
    ) u_pick (
        .brk_req (brk_req),
        .brk_trap(brk_trap),
        .mmu_req (mmu_req),
        .irq_pend(irq_pend),
        .irq_en  (cur_ccs[IFLAG_BIT]),
        .take_o  (take),
        .is_brk_o(is_brk),
        .vec_o   (vec)
    );

    exc_ccs_shift #(
        .XLEN (XLEN),
        .KEEP (CCS_KEEP),
        .SHIFT(CCS_SHIFT)
    ) u_shift (
        .ccs_i(cur_ccs),
        .ccs_o(ccs_shifted)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (take) begin
                    d.state = ST_REQ;
                    d.addr  = ebp + XLEN'({vec, 2'b00});
                    d.erp_h = is_brk ? cur_pc + XLEN'(BRK_STEP) : cur_pc;
                    d.ccs_h = ccs_shifted;
                end
            end
            ST_REQ: begin
                if (rd_ready) d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_rvalid) begin
                    d.state = ST_DONE;
                    d.pc    = rd_rdata;
                    d.erp   = q.erp_h;
                    d.ccs   = q.ccs_h;
                    d.done  = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_valid = (q.state == ST_REQ);
    assign rd_addr  = q.addr;
    assign done     = q.done;
    assign new_pc   = q.pc;
    assign new_erp  = q.erp;
    assign new_ccs  = q.ccs;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int XLEN      = 32,
    parameter int CCS_SHIFT = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_valid,
    input logic            rd_ready,
    input logic [XLEN-1:0] rd_addr,
    input logic            done,
    input logic [XLEN-1:0] new_pc,
    input logic [XLEN-1:0] new_erp,
    input logic [XLEN-1:0] new_ccs
);
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_results_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(new_pc) && $stable(new_erp) && $stable(new_ccs)));

    assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !rd_valid);

    assert_no_req_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_valid);

    assert_ccs_low_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_ccs[CCS_SHIFT-1:0] == '0));
endmodule

bind exc_entry_seq exc_entry_chk #(
    .XLEN     (XLEN),
    .CCS_SHIFT(CCS_SHIFT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_valid(rd_valid),
    .rd_ready(rd_ready),
    .rd_addr (rd_addr),
    .done    (done),
    .new_pc  (new_pc),
    .new_erp (new_erp),
    .new_ccs (new_ccs)
);

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        brk_req = 1'b0;
    logic [7:0]  brk_trap = '0;
    logic        mmu_req = 1'b0;
    logic [31:0] irq_pend = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_ccs = '0;
    logic [31:0] ebp = '0;
    logic        rd_valid;
    logic [31:0] rd_addr;
    logic        rd_ready = 1'b0;
    logic        rd_rvalid = 1'b0;
    logic [31:0] rd_rdata = '0;
    logic        done;
    logic [31:0] new_pc, new_erp, new_ccs;

    int checks = 0;
    int fails  = 0;
    string cur_tag = "R8";

    always #2.5 clk = ~clk;

    exc_entry_seq uut (
        .clk(clk), .rst_n(rst_n),
        .brk_req(brk_req), .brk_trap(brk_trap), .mmu_req(mmu_req),
        .irq_pend(irq_pend), .cur_pc(cur_pc), .cur_ccs(cur_ccs), .ebp(ebp),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .done(done), .new_pc(new_pc), .new_erp(new_erp), .new_ccs(new_ccs)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return ~a ^ 32'h1357_9BDF;
    endfunction

    // ---------------- reference model ----------------
    int          m_phase = 0;   // 0 idle, 1 asking, 2 awaiting data, 3 strobe
    logic [31:0] m_addr = '0, m_erp_h = '0, m_ccs_h = '0;
    logic [31:0] m_pc = '0, m_erp = '0, m_ccs = '0;
    logic        m_done = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_addr = '0; m_erp_h = '0; m_ccs_h = '0;
            m_pc = '0; m_erp = '0; m_ccs = '0; m_done = 1'b0;
        end else begin
            case (m_phase)
                0: begin
                    int vnum;
                    bit got;
                    m_done = 1'b0;
                    got = 1'b0;
                    vnum = 0;
                    if (brk_req) begin
                        vnum = int'(brk_trap); m_erp_h = cur_pc + 32'd2; got = 1'b1;
                    end else if (mmu_req) begin
                        vnum = 4; m_erp_h = cur_pc; got = 1'b1;
                    end else if (irq_pend != 0 && cur_ccs[8]) begin
                        for (int k = 0; k < 32; k++) if (irq_pend[k]) vnum = 48 + k;
                        m_erp_h = cur_pc; got = 1'b1;
                    end
                    if (got) begin
                        m_addr  = ebp + 32'(vnum * 4);
                        m_ccs_h = {cur_ccs[31:30], cur_ccs[19:0], 10'd0};
                        m_phase = 1;
                    end
                end
                1: if (rd_ready) m_phase = 2;
                2: if (rd_rvalid) begin
                    m_pc = rd_rdata; m_erp = m_erp_h; m_ccs = m_ccs_h;
                    m_done = 1'b1; m_phase = 3;
                end
                default: begin m_done = 1'b0; m_phase = 0; end
            endcase
        end
    end

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cmp("rd_valid", {31'd0, rd_valid}, {31'd0, m_phase == 1});
            if (m_phase == 1) cmp("rd_addr (R1)", rd_addr, m_addr);
            cmp("done", {31'd0, done}, {31'd0, m_done});
            cmp("new_pc (R1)", new_pc, m_pc);
            cmp("new_erp", new_erp, m_erp);
            cmp("new_ccs (R6)", new_ccs, m_ccs);
        end
    end

    // ---------------- memory responder ----------------
    int          ready_dly = 0, resp_dly = 0;
    int          rs = 0, rcnt = 0;
    logic [31:0] lat_addr = '0;

    always @(negedge clk) begin
        rd_ready  = 1'b0;
        rd_rvalid = 1'b0;
        rd_rdata  = '0;
        if (rs == 0) begin
            if (rd_valid) begin
                if (rcnt >= ready_dly) begin
                    rd_ready = 1'b1; lat_addr = rd_addr; rs = 1; rcnt = 0;
                end else rcnt++;
            end
        end else begin
            if (rcnt >= resp_dly) begin
                rd_rvalid = 1'b1; rd_rdata = mem_word(lat_addr); rs = 0; rcnt = 0;
            end else rcnt++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic fire(input logic b, input logic [7:0] t, input logic m,
                        input logic [31:0] irq, input logic [31:0] pc,
                        input logic [31:0] ccs, input logic [31:0] base,
                        input string tag);
        @(negedge clk);
        cur_tag = tag;
        brk_req = b; brk_trap = t; mmu_req = m; irq_pend = irq;
        cur_pc = pc; cur_ccs = ccs; ebp = base;
        @(negedge clk);
        brk_req = 1'b0; mmu_req = 1'b0; irq_pend = '0;
        repeat (16) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state, R8
        cur_tag = "R8";
        cmp("reset rd_valid", {31'd0, rd_valid}, 32'd0);
        cmp("reset done", {31'd0, done}, 32'd0);
        cmp("reset new_pc", new_pc, 32'd0);
        cmp("reset new_erp", new_erp, 32'd0);
        cmp("reset new_ccs", new_ccs, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2 break, R6 status shift
        fire(1, 8'd5, 0, 0, 32'h0000_1000, 32'hC00A_BDEF, 32'h0000_8000, "R2");
        // R3 miss
        fire(0, 8'd0, 1, 0, 32'h0000_2222, 32'h4001_2345, 32'h0001_0000, "R3");
        // R4 interrupts: bits 7 and 3 -> 0x37
        fire(0, 8'd0, 0, 32'h0000_0088, 32'h0000_3330, 32'h8000_0100, 32'h0002_0000, "R4");
        ready_dly = 2; resp_dly = 3;
        fire(0, 8'd0, 0, 32'h8000_0001, 32'h0000_4440, 32'h0000_0100, 32'h0002_0000, "R4");
        fire(0, 8'd0, 0, 32'h0000_0001, 32'h0000_5550, 32'hFFFF_FFFF, 32'h0002_0000, "R4");
        // R5 enable clear, and nothing pending
        fire(0, 8'd0, 0, 32'hFFFF_FFFF, 32'h0000_6660, 32'hFFFF_FEFF, 32'h0003_0000, "R5");
        fire(0, 8'd0, 0, 32'h0000_0000, 32'h0000_6664, 32'h0000_0100, 32'h0003_0000, "R5");
        // R7 priority
        ready_dly = 0; resp_dly = 1;
        fire(1, 8'd9, 1, 32'h0000_0010, 32'h0000_7770, 32'h0000_0100, 32'h0004_0000, "R7");
        fire(0, 8'd0, 1, 32'h0000_0010, 32'h0000_7774, 32'h0000_0100, 32'h0004_0000, "R7");
        // R10 wrap of PC and address
        fire(1, 8'hFF, 0, 0, 32'hFFFF_FFFF, 32'h3FFF_FFFF, 32'hFFFF_FFF0, "R10");
        // R9 requests during a slow fetch are ignored
        ready_dly = 3; resp_dly = 4;
        @(negedge clk);
        cur_tag = "R9";
        mmu_req = 1'b1; cur_pc = 32'h0000_9990; cur_ccs = 32'h0000_0100; ebp = 32'h0005_0000;
        @(negedge clk);
        mmu_req = 1'b0;
        @(negedge clk);
        brk_req = 1'b1; brk_trap = 8'h21; irq_pend = 32'h0000_0400;
        repeat (4) @(negedge clk);
        brk_req = 1'b0; irq_pend = '0;
        repeat (14) @(negedge clk);
        cmp("erp after ignored requests", new_erp, 32'h0000_9990);
        cmp("pc after ignored requests", new_pc, mem_word(32'h0005_0010));
        // R1 explicit handler check on a break
        ready_dly = 0; resp_dly = 0;
        fire(1, 8'd2, 0, 0, 32'h0000_0100, 32'h0000_0000, 32'h0000_0400, "R1");
        cmp("handler", new_pc, mem_word(32'h0000_0408));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule